// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block sits between the transmit data source and the cable driver and stops a node that will not stop transmitting. It counts the clock cycles of each unbroken stretch of transmit activity. When a stretch outlasts a programmable window (nominally 50 ms), the block cuts the data path to the driver and asserts a collision-indication request for the attachment side.

Once activity stops, the block holds the cut and the collision request for a further quiet interval (nominally 0.5 s, tolerance ±50%) before it returns to normal. Any activity during that interval starts the quiet count again. Link-integrity pulse requests pass straight to the driver whenever link integrity is enabled, in every state including the jabber states. Both intervals are parameters counted in clock cycles, so a simulation can use short values.

Top module: `tx_jabber_guard`

## Requirements
- R1: After reset, and after a reset applied while jabber is active, inhibit_o and col_req_o are low, and drv_en_o follows tx_act_i.
- R2: A run of at most WINDOW_CYC consecutive cycles with tx_act_i high leaves inhibit_o low. During such a run drv_en_o equals tx_act_i and drv_data_o equals tx_data_i.
- R3: inhibit_o and col_req_o both rise on the clock edge that samples the (WINDOW_CYC+1)-th consecutive cycle of tx_act_i high.
- R4: A single cycle with tx_act_i low clears the window count. The next run again gets a full WINDOW_CYC cycles without tripping.
- R5: While inhibit_o is high, drv_en_o is low and drv_data_o is all zeros.
- R6: After activity stops, inhibit_o and col_req_o stay high. They fall on the edge that samples the (UNJAB_CYC+1)-th consecutive cycle of tx_act_i low.
- R7: If tx_act_i goes high during the quiet interval, inhibit_o stays high and the quiet count restarts. Release then needs UNJAB_CYC+1 consecutive low cycles after the last active cycle.
- R8: drv_link_o equals link_pulse_i when link_en_i is high, in every state, including while inhibit_o is high. drv_link_o is low when link_en_i is low.
- R9: A burst far longer than the counter range keeps inhibit_o high for the whole burst. The count does not wrap, so the burst does not end the jabber state early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_act_i | input | 1 | Transmit activity present |
| tx_data_i | input | DW | Transmit data toward the driver |
| link_pulse_i | input | 1 | Link-integrity pulse request |
| link_en_i | input | 1 | Link-integrity function enabled |
| drv_en_o | output | 1 | Driver enable: activity that is not inhibited |
| drv_data_o | output | DW | Gated data to the driver, zero while inhibited |
| drv_link_o | output | 1 | Link pulse to the driver |
| inhibit_o | output | 1 | Transmit inhibited by jabber |
| col_req_o | output | 1 | Collision-indication request |

## Verification
The bench applies several activity patterns, and each one separates a different behaviour:
- A run of exactly WINDOW_CYC cycles against a run of WINDOW_CYC+1 cycles locates the trip edge to the cycle.
- Two full-window runs split by a one-cycle gap show that the count restarts.
- A quiet interval of UNJAB_CYC+5 cycles, and a short burst placed inside the quiet interval, locate the release edge and show that the quiet count restarts.
- A 300-cycle burst shows that the count saturates and does not wrap.

Link pulses toggle throughout, with link_en_i both high and low, to show they pass unaffected by the inhibit. A reset applied during jabber shows that reset returns the block to idle.

// File: rtl/tx_jabber_guard.sv
module tx_jabber_guard #(
  parameter int DW         = 8,
  parameter int WINDOW_CYC = 1_000_000,
  parameter int UNJAB_CYC  = 10_000_000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_act_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          link_pulse_i,
  input  logic          link_en_i,
  output logic          drv_en_o,
  output logic [DW-1:0] drv_data_o,
  output logic          drv_link_o,
  output logic          inhibit_o,
  output logic          col_req_o
);
  localparam int LIM = (WINDOW_CYC > UNJAB_CYC) ? WINDOW_CYC : UNJAB_CYC;
  localparam int CW  = $clog2(LIM + 2);
  localparam logic [CW-1:0] WIN_END = CW'(WINDOW_CYC);
  localparam logic [CW-1:0] UNJ_END = CW'(UNJAB_CYC);
  localparam logic [CW-1:0] CNT_MAX = '1;

  typedef enum logic [1:0] {S_IDLE, S_ACTIVE, S_JABBER, S_UNJAB} state_t;

  state_t        st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d, cnt_inc;
  logic          blocked;

  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      S_IDLE: if (tx_act_i) begin
        st_d  = S_ACTIVE;
        cnt_d = CW'(1);
      end
      S_ACTIVE: begin
        if (!tx_act_i) begin
          st_d  = S_IDLE;
          cnt_d = '0;
        end else if (cnt_q == WIN_END) begin
          st_d  = S_JABBER;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      S_JABBER: if (!tx_act_i) begin
        st_d  = S_UNJAB;
        cnt_d = CW'(1);
      end
      S_UNJAB: begin
        if (tx_act_i) begin
          st_d  = S_JABBER;
          cnt_d = '0;
        end else if (cnt_q == UNJ_END) begin
          st_d  = S_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      default: begin
        st_d  = S_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign blocked    = (st_q == S_JABBER) || (st_q == S_UNJAB);
  assign inhibit_o  = blocked;
  assign col_req_o  = blocked;
  assign drv_en_o   = tx_act_i & ~blocked;
  assign drv_data_o = blocked ? '0 : tx_data_i;
  assign drv_link_o = link_pulse_i & link_en_i;
endmodule

// File: rtl/tx_jabber_guard_chk.sv
module tx_jabber_guard_chk #(
  parameter int DW         = 8,
  parameter int WINDOW_CYC = 1_000_000,
  parameter int UNJAB_CYC  = 10_000_000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_act_i,
  input logic          link_pulse_i,
  input logic          link_en_i,
  input logic          drv_en_o,
  input logic [DW-1:0] drv_data_o,
  input logic          drv_link_o,
  input logic          inhibit_o,
  input logic          col_req_o
);
  localparam int CAP = ((WINDOW_CYC > UNJAB_CYC) ? WINDOW_CYC : UNJAB_CYC) + 2;

  int run_q, quiet_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 0;
      quiet_q <= 0;
    end else if (tx_act_i) begin
      run_q   <= (run_q < CAP) ? run_q + 1 : run_q;
      quiet_q <= 0;
    end else begin
      run_q   <= 0;
      quiet_q <= (quiet_q < CAP) ? quiet_q + 1 : quiet_q;
    end
  end

  AST_TRIP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inhibit_o) |-> (run_q == WINDOW_CYC + 1)); // R3
  AST_COL_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inhibit_o) |-> col_req_o); // R3
  AST_NO_EARLY_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!inhibit_o) && run_q <= WINDOW_CYC) |-> !inhibit_o); // R2
  AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_o |-> (!drv_en_o && drv_data_o == '0)); // R5
  AST_RELEASE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inhibit_o) |-> (quiet_q == UNJAB_CYC + 1)); // R6
  AST_RESUME_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_o && tx_act_i) |=> inhibit_o); // R7
  AST_LINK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (link_en_i && link_pulse_i) |-> drv_link_o); // R8
  AST_LINK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !link_en_i |-> !drv_link_o); // R8
endmodule

bind tx_jabber_guard tx_jabber_guard_chk #(
  .DW(DW), .WINDOW_CYC(WINDOW_CYC), .UNJAB_CYC(UNJAB_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_act_i(tx_act_i),
  .link_pulse_i(link_pulse_i), .link_en_i(link_en_i),
  .drv_en_o(drv_en_o), .drv_data_o(drv_data_o), .drv_link_o(drv_link_o),
  .inhibit_o(inhibit_o), .col_req_o(col_req_o)
);

// File: tb/tx_jabber_guard_bench.sv
`timescale 1ns/1ps
module tx_jabber_guard_bench;
  localparam int DW = 8;
  localparam int W  = 40;
  localparam int U  = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_act = 1'b0, lp = 1'b0, le = 1'b0;
  logic [DW-1:0] tx_data = '0;
  logic drv_en, drv_link, inhibit, col_req;
  logic [DW-1:0] drv_data;

  always #2 clk = ~clk;

  tx_jabber_guard #(.DW(DW), .WINDOW_CYC(W), .UNJAB_CYC(U)) u_tx_jabber_guard (
    .clk(clk), .rst_n(rst_n), .tx_act_i(tx_act), .tx_data_i(tx_data),
    .link_pulse_i(lp), .link_en_i(le), .drv_en_o(drv_en), .drv_data_o(drv_data),
    .drv_link_o(drv_link), .inhibit_o(inhibit), .col_req_o(col_req)
  );

  typedef struct {
    logic          inh;
    logic          en;
    logic [DW-1:0] data;
    logic          link;
    string         tag;
  } exp_t;

  exp_t sb[$];
  int vectors = 0, errors = 0;
  bit m_jab = 0;
  int m_run = 0, m_quiet = 0;

  task automatic cmp(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp, input string what);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic a, input logic [DW-1:0] d, input logic p, input logic e, input string tag);
    exp_t x;
    @(negedge clk);
    tx_act = a; tx_data = d; lp = p; le = e;
    @(posedge clk);
    if (!m_jab) begin
      if (a) begin
        m_run++;
        if (m_run > W) begin m_jab = 1; m_quiet = 0; end
      end else m_run = 0;
    end else begin
      if (a) m_quiet = 0;
      else begin
        m_quiet++;
        if (m_quiet > U) begin m_jab = 0; m_run = 0; end
      end
    end
    x.inh  = m_jab;
    x.en   = a & ~m_jab;
    x.data = m_jab ? '0 : d;
    x.link = p & e;
    x.tag  = tag;
    sb.push_back(x);
  endtask

  task automatic burst(input int n, input logic a, input logic e, input string tag);
    for (int i = 0; i < n; i++)
      step(a, DW'(i * 7 + 3), i[1], e, tag);
  endtask

  initial begin : monitor
    exp_t x;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        x = sb.pop_front();
        cmp(x.tag, DW'(inhibit), DW'(x.inh), "inhibit_o");
        cmp(x.tag, DW'(col_req), DW'(x.inh), "col_req_o");
        cmp(x.tag, DW'(drv_en), DW'(x.en), "drv_en_o");
        cmp(x.tag, drv_data, x.data, "drv_data_o");
        cmp(x.tag, DW'(drv_link), DW'(x.link), "drv_link_o");
      end
    end
  end

  initial begin : watchdog
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    cmp("R1", DW'(inhibit), '0, "inhibit_o in reset");
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1", DW'(col_req), '0, "col_req_o after reset");
    cmp("R1", DW'(drv_en), '0, "drv_en_o after reset");

    burst(W, 1, 1, "R2");
    burst(3, 0, 1, "R2");
    burst(W, 1, 1, "R4");
    burst(1, 0, 1, "R4");
    burst(W, 1, 1, "R4");
    burst(4, 0, 1, "R4");

    burst(W, 1, 1, "R3");
    burst(5, 1, 1, "R5 R8");
    burst(U + 5, 0, 1, "R6 R8");

    burst(W + 2, 1, 1, "R3");
    burst(30, 0, 1, "R6");
    burst(3, 1, 1, "R7");
    burst(U + 3, 0, 1, "R7");

    burst(300, 1, 0, "R9 R8");
    burst(U + 2, 0, 0, "R6");

    burst(W + 3, 1, 1, "R3");
    @(negedge clk);
    tx_act = 1'b0;
    rst_n = 1'b0;
    m_jab = 0; m_run = 0; m_quiet = 0;
    @(negedge clk);
    cmp("R1", DW'(inhibit), '0, "inhibit_o after reset in jabber");
    cmp("R1", DW'(col_req), '0, "col_req_o after reset in jabber");
    rst_n = 1'b1;
    burst(5, 1, 1, "R1");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule